// File: doc/BRIEF.md
# UART Transmit Serializer

This block turns parallel characters into an asynchronous serial stream. A character written into the one-entry holding register is copied into a separate shift register. It then leaves on the serial line as a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then a stop period of one, one and a half or two bit times. Between characters the line rests high.

Bit timing comes from a one-clock tick input that an external baud generator pulses on each overflow. Sixteen ticks make one bit time (parameter `OSR`), so half a stop bit is eight ticks. A new character begins on the first tick at which the engine is free and the holding register is full. The holding register empties on that same tick, so the next character can be written while the current one is still shifting out.

Two controls change the line behaviour. With flow control enabled, a deasserted clear-to-send input holds back the start of every new character; a character already on the line is sent to the end. A break control drives the line low for as long as it is set, while the serializer keeps its place in the frame underneath.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset `txd` is 1, `wr_ready` is 1 and `tx_idle` is 1.
- R2: A write (`wr_valid` high while `wr_ready` is 1) is captured and drops `wr_ready` on the next clock. A write offered while `wr_ready` is 0 is ignored, and the character already held is the one transmitted.
- R3: With the engine idle and a character held, the start bit (0) appears on `txd` one clock after the first `tick` that follows the write. A bit index counted from that tick (tick 0) is floor(k/16).
- R4: Data bits follow the start bit, least significant first. `cfg_len` code n in 0..4 selects 5+n data bits, and codes 5..7 select 9.
- R5: `cfg_par` 01 appends an odd-parity bit and 10 an even-parity bit, each computed over the sent data bits. Codes 00 and 11 send no parity.
- R6: The stop period is high and lasts 16 ticks for `cfg_stop` 00, 24 ticks for 01, and 32 ticks for 10 or 11. With a character waiting, the next start bit begins exactly when the stop period ends.
- R7: The holding register empties (`wr_ready` 1) on the tick at which its character enters the shift register. A character written during the current frame follows it with no idle gap.
- R8: With `flow_en` 1 and `cts` 0, no new character starts: `txd` stays high and `tx_idle` stays 1. A frame already started completes unchanged. With `flow_en` 0, `cts` has no effect.
- R9: While `cfg_break` is 1, `txd` is 0 from the next clock. The frame underneath keeps its timing, so the bits after the break is released are the bits that were due at those ticks.
- R10: Each frame bit holds for 16 ticks, and `txd` is high whenever no frame is being sent and no break is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Baud-generator overflow pulse, 16 per bit time |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send; unused upper bits ignored |
| wr_ready | output | 1 | Holding register empty |
| cfg_len | input | 3 | Data length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| cfg_break | input | 1 | Force the line low |
| flow_en | input | 1 | Enable clear-to-send hold-off |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output, idles high |
| tx_idle | output | 1 | Shift engine has no frame in progress |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and 5 to 9 data bits. At this size every combination of length, parity and stop code (45 in all) can be swept, each as a back-to-back pair of characters. Because the bench drives every tick itself, it predicts the line value after every single tick from the frame arithmetic. That exposes off-by-one bit spans, the eight-tick half stop bit, and any gap at the seam between two frames. Separate sequences hold off starts with clear-to-send, drop it in mid-frame, and lay a break over a frame in flight.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BITS = 2'd1,
    ST_STOP = 2'd2
  } tx_state_e;

  localparam logic [1:0] PAR_ODD  = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;

  localparam logic [1:0] STOP_ONE  = 2'b00;
  localparam logic [1:0] STOP_HALF = 2'b01;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          hold_full,
  output logic [DW-1:0] hold_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (wr_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end
  end

  // R2: an occupied holding register keeps its character until it is taken
  a_r2_hold_refuses: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DMIN = 5,
  parameter int DMAX = 9,
  parameter int LW   = 3,
  parameter int FW   = DMAX + 2,
  parameter int BW   = $clog2(FW + 1)
) (
  input  logic [DMAX-1:0] data,
  input  logic [LW-1:0]   len_code,
  input  logic [1:0]      par_code,
  output logic [FW-1:0]   frame,
  output logic [BW-1:0]   nbits
);
  localparam int NCODES = DMAX - DMIN + 1;

  int   nd;
  logic par_on;
  logic p;

  always_comb begin
    nd     = (int'(len_code) >= NCODES) ? DMAX : DMIN + int'(len_code);
    par_on = (par_code == PAR_ODD) || (par_code == PAR_EVEN);
    frame  = '1;
    frame[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < DMAX; i++) begin
      if (i < nd) begin
        frame[i+1] = data[i];
        p = p ^ data[i];
      end
    end
    if (par_on) frame[nd+1] = (par_code == PAR_ODD) ? ~p : p;
    nbits = BW'(1 + nd + (par_on ? 1 : 0));
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int FW  = 11,
  parameter int BW  = $clog2(FW + 1),
  parameter int SW  = $clog2(2 * OSR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          can_start,
  input  logic [FW-1:0] frame,
  input  logic [BW-1:0] nbits,
  input  logic [SW-1:0] stop_ticks,
  output logic          take,
  output logic          line,
  output logic          idle
);
  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] TLAST = TW'(OSR - 1);

  tx_state_e     state;
  logic [FW-1:0] shreg;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bleft;
  logic [SW-1:0] scnt;

  assign take = tick && can_start &&
                ((state == ST_IDLE) || (state == ST_STOP && scnt == '0));
  assign line = (state == ST_BITS) ? shreg[0] : 1'b1;
  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      shreg <= '1;
      tcnt  <= '0;
      bleft <= '0;
      scnt  <= '0;
    end else if (take) begin
      state <= ST_BITS;
      shreg <= frame;
      bleft <= nbits;
      tcnt  <= '0;
      scnt  <= '0;
    end else if (tick) begin
      case (state)
        ST_BITS: begin
          if (tcnt == TLAST) begin
            tcnt  <= '0;
            shreg <= {1'b1, shreg[FW-1:1]};
            bleft <= bleft - 1'b1;
            if (bleft == BW'(1)) begin
              state <= ST_STOP;
              scnt  <= stop_ticks - 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (scnt == '0) state <= ST_IDLE;
          else            scnt  <= scnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: the bit on the line only moves at the end of a 16-tick span
  a_r10_bit_span: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && !(tick && tcnt == TLAST)) |=> $stable(shreg));
  // R6: the stop counter never exceeds the two-bit stop length
  a_r6_stop_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> (int'(scnt) < 2 * OSR));
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int DMIN = 5,
  parameter int DMAX = 9,
  parameter int LW   = $clog2(DMAX - DMIN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            wr_valid,
  input  logic [DMAX-1:0] wr_data,
  output logic            wr_ready,
  input  logic [LW-1:0]   cfg_len,
  input  logic [1:0]      cfg_par,
  input  logic [1:0]      cfg_stop,
  input  logic            cfg_break,
  input  logic            flow_en,
  input  logic            cts,
  output logic            txd,
  output logic            tx_idle
);
  localparam int FW = DMAX + 2;
  localparam int BW = $clog2(FW + 1);
  localparam int SW = $clog2(2 * OSR + 1);

  logic            hold_full;
  logic [DMAX-1:0] hold_data;
  logic            take;
  logic [FW-1:0]   frame;
  logic [BW-1:0]   nbits;
  logic [SW-1:0]   stop_ticks;
  logic            line;
  logic            can_start;

  uart_tx_hold #(.DW(DMAX)) u_hold (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(take), .hold_full(hold_full), .hold_data(hold_data)
  );

  uart_tx_frame #(.DMIN(DMIN), .DMAX(DMAX), .LW(LW), .FW(FW), .BW(BW)) u_frame (
    .data(hold_data), .len_code(cfg_len), .par_code(cfg_par),
    .frame(frame), .nbits(nbits)
  );

  always_comb begin
    case (cfg_stop)
      STOP_ONE:  stop_ticks = SW'(OSR);
      STOP_HALF: stop_ticks = SW'(OSR + OSR / 2);
      default:   stop_ticks = SW'(2 * OSR);
    endcase
  end

  assign can_start = hold_full && (!flow_en || cts);

  uart_tx_shift #(.OSR(OSR), .FW(FW), .BW(BW), .SW(SW)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .can_start(can_start),
    .frame(frame), .nbits(nbits), .stop_ticks(stop_ticks),
    .take(take), .line(line), .idle(tx_idle)
  );

  assign wr_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= cfg_break ? 1'b0 : line;
  end

  // R9: a set break pulls the line low on the following clock
  a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
    cfg_break |=> !txd);
  // R10: no frame and no break means a high line
  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!cfg_break && tx_idle) |=> txd);
  // R3: a frame only starts on a tick
  a_r3_start_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_idle) |-> $past(tick));
  // R7: the engine only loads from an occupied holding register
  a_r7_take_needs_char: assert property (@(posedge clk) disable iff (rst)
    take |-> hold_full);
  // R8: hold-off keeps an idle engine idle
  a_r8_cts_holds: assert property (@(posedge clk) disable iff (rst)
    (flow_en && !cts && tx_idle) |=> tx_idle);
endmodule

// File: tb/test_uart_tx_serializer.sv
module test_uart_tx_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_par = 2'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic       cfg_break = 1'b0;
  logic       flow_en = 1'b0;
  logic       cts = 1'b0;
  logic       txd;
  logic       tx_idle;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_tx_serializer i_uart_tx_serializer (
    .clk(clk), .rst(rst), .tick(tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .cfg_break(cfg_break), .flow_en(flow_en), .cts(cts), .txd(txd), .tx_idle(tx_idle)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int n_data(input int len);
    return (len > 4) ? 9 : 5 + len;
  endfunction

  function automatic int n_bits(input int len, input int par);
    return 1 + n_data(len) + ((par == 1 || par == 2) ? 1 : 0);
  endfunction

  function automatic int stop_len(input int st);
    return (st == 0) ? 16 : (st == 1) ? 24 : 32;
  endfunction

  function automatic logic exp_bit(input logic [8:0] d, input int len, input int par, input int k);
    int nd = n_data(len);
    int idx = k / 16;
    logic p = 1'b0;
    if (idx >= n_bits(len, par)) return 1'b1;
    if (idx == 0) return 1'b0;
    if (idx <= nd) return d[idx-1];
    for (int i = 0; i < nd; i++) p ^= d[i];
    return (par == 1) ? ~p : p;
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] d);
    wr_valid = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_pair(input logic [8:0] a, input logic [8:0] b);
    int len = int'(cfg_len);
    int par = int'(cfg_par);
    int k0 = 16 * n_bits(len, par) + stop_len(int'(cfg_stop));
    int bad = 0;
    int first_k = -1;
    logic e;
    wr(a);
    chk(wr_ready == 1'b0, "R2 ready drops after write", int'(wr_ready), 0);
    wr(~a);
    for (int k = 0; k < 2 * k0 + 2; k++) begin
      do_tick();
      if (k == 0) begin
        chk(wr_ready == 1'b1, "R7 holding empties on start tick", int'(wr_ready), 1);
        wr(b);
      end
      e = (k < k0) ? exp_bit(a, len, par, k) : (k < 2 * k0) ? exp_bit(b, len, par, k - k0) : 1'b1;
      if (txd !== e) begin
        bad++;
        if (first_k < 0) first_k = k;
      end
    end
    if (bad != 0)
      $display("  mismatch len=%0d par=%0d stop=%0d first at tick %0d", len, par, cfg_stop, first_k);
    chk(bad == 0, "R3 R4 R5 R6 R10 frame pair bit mismatches", bad, 0);
    chk(tx_idle == 1'b1, "R7 idle after pair", int'(tx_idle), 1);
  endtask

  initial begin
    int bad;
    logic [8:0] a;
    logic [8:0] b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(wr_ready == 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);
    chk(tx_idle == 1'b1, "R1 tx_idle after reset", int'(tx_idle), 1);

    // sweep every length, parity and stop code; cts low with flow_en 0 (R8)
    for (int l = 0; l < 5; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 3; s++) begin
          cfg_len = 3'(l);
          cfg_par = 2'(p);
          cfg_stop = 2'(s);
          a = 9'((l * 113 + p * 37 + s * 71 + 9'h0A5) & 9'h1FF);
          b = 9'((~(l * 29 + p * 53 + s * 17)) & 9'h1FF);
          run_pair(a, b);
        end
    // codes 5..7 behave as 9 bits, code 3 parity none (R4, R5)
    cfg_len = 3'd7; cfg_par = 2'd3; cfg_stop = 2'd3;
    run_pair(9'h155, 9'h0F3);

    // R8: cts hold-off
    cfg_len = 3'd3; cfg_par = 2'd0; cfg_stop = 2'd0;
    flow_en = 1'b1; cts = 1'b0;
    wr(9'h0C3);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      do_tick();
      if (txd !== 1'b1 || tx_idle !== 1'b1) bad++;
    end
    chk(bad == 0, "R8 no start while cts low", bad, 0);
    chk(wr_ready == 1'b0, "R8 character still held", int'(wr_ready), 0);
    cts = 1'b1;
    bad = 0;
    for (int k = 0; k < 16 * 10 + 20; k++) begin
      do_tick();
      if (k == 20) cts = 1'b0;
      if (txd !== exp_bit(9'h0C3, 3, 0, k)) bad++;
    end
    chk(bad == 0, "R8 frame completes after cts drops", bad, 0);
    wr(9'h011);
    for (int k = 0; k < 30; k++) do_tick();
    chk(tx_idle == 1'b1, "R8 second char held off", int'(tx_idle), 1);
    cts = 1'b1;
    for (int k = 0; k < 16 * 10 + 20; k++) do_tick();
    flow_en = 1'b0;
    chk(tx_idle == 1'b1 && wr_ready == 1'b1, "R8 released char sent", int'(tx_idle), 1);

    // R9: break when idle and over a frame
    cfg_break = 1'b1;
    do_tick();
    chk(txd == 1'b0, "R9 break drives low", int'(txd), 0);
    chk(tx_idle == 1'b1, "R9 break starts nothing", int'(tx_idle), 1);
    cfg_break = 1'b0;
    do_tick();
    chk(txd == 1'b1, "R9 break released high", int'(txd), 1);
    cfg_par = 2'd2;
    wr(9'h0B6);
    bad = 0;
    for (int k = 0; k < 16 * 11 + 20; k++) begin
      if (k == 16) cfg_break = 1'b1;
      if (k == 48) cfg_break = 1'b0;
      do_tick();
      if (txd !== ((k >= 16 && k < 48) ? 1'b0 : exp_bit(9'h0B6, 3, 2, k))) bad++;
    end
    chk(bad == 0, "R9 frame timing kept under break", bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule